// File: doc/BRIEF.md
# Rounding Complex Multiplier for Carrier Wipeoff

This block is a streaming stage that strips a carrier from baseband samples. Each accepted beat carries two signed complex operands: the sample and the local carrier value (cosine on the real part, sine on the imaginary part). The block forms their full complex product. It adds a rounding constant of half an output step, shifts both parts right arithmetically by a shift amount that is supplied with the beat, and clamps the results into signed 16-bit real and imaginary words.

A block of samples is processed element by element, giving one product for every operand pair, in the order the pairs were accepted. A typical carrier-wipeoff setting scales by 2^-14, so a shift of 14. The carrier generator and any accumulation of the products sit outside this block. The pipeline has three fixed register stages: multiply, sum/round, and shift/saturate. The output valid is delayed to match, and the output has no backpressure.

Top module: `cplx_rnd_mul`

## Requirements
- R1: Before scaling, the real result equals a_re*b_re - a_im*b_im, computed without wrap for all signed 16-bit operands.
- R2: Before scaling, the imaginary result equals a_re*b_im + a_im*b_re, computed without wrap for all signed 16-bit operands.
- R3: For a shift s in 1..31, 2^(s-1) is added to both sums before shifting, so results round half toward +infinity.
- R4: A shift of 0 adds no rounding term; the output is the exact sum, saturated.
- R5: The shift right is arithmetic: negative sums stay negative, and the result is floor((sum + round) / 2^s).
- R6: Results above 32767 become 32767 and results below -32768 become -32768, on each part independently.
- R7: A beat accepted at a clock edge (in_vld_i and in_rdy_o high) gives out_vld_o high with its result exactly three edges later. There is one output per accepted beat, in acceptance order.
- R8: Cycles with no accepted beat produce no output valid; out_vld_o is low in reset.
- R9: The shift amount is captured with each beat, so consecutive beats may use different shifts without affecting each other.
- R10: in_rdy_o is low while rst_ni is low and high from the first edge after reset release onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Operand beat valid |
| in_rdy_o | output | 1 | Block accepts beats |
| a_re_i | input | 16 | Sample real part, signed |
| a_im_i | input | 16 | Sample imaginary part, signed |
| b_re_i | input | 16 | Carrier real part (cosine), signed |
| b_im_i | input | 16 | Carrier imaginary part (sine), signed |
| shift_i | input | 5 | Right shift amount for this beat |
| out_vld_o | output | 1 | Result valid |
| out_re_o | output | 16 | Rounded, shifted, saturated real result |
| out_im_o | output | 16 | Rounded, shifted, saturated imaginary result |

## Verification
The bench builds the block with its default 16-bit operands and a 5-bit shift field, so every shift from 0 to 31 can be driven. It sweeps all combinations of the five extreme operand values {-32768, -1, 0, 1, 32767} across every shift. This reaches both saturation limits, the one sum that needs a 33rd bit (-32768 squared twice), the bypassed rounding at shift 0, and the half-step rounding of negative values. Random operands with random shifts and idle gaps then exercise per-beat shift capture, pipeline ordering and the three-edge latency.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  typedef enum logic {LANE_RE = 1'b0, LANE_IM = 1'b1} lane_e;
  localparam int unsigned WIPEOFF_SHIFT = 14;
endpackage

// File: rtl/cmul_prod_stage.sv
module cmul_prod_stage #(
  parameter int unsigned DW  = 16,
  parameter int unsigned SHW = 5,
  localparam int unsigned PW = 2 * DW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic signed [DW-1:0]  a_re_i,
  input  logic signed [DW-1:0]  a_im_i,
  input  logic signed [DW-1:0]  b_re_i,
  input  logic signed [DW-1:0]  b_im_i,
  input  logic [SHW-1:0]        shift_i,
  output logic                  vld_o,
  output logic signed [PW-1:0]  p_rr_o,
  output logic signed [PW-1:0]  p_ii_o,
  output logic signed [PW-1:0]  p_ri_o,
  output logic signed [PW-1:0]  p_ir_o,
  output logic [SHW-1:0]        shift_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      p_rr_o  <= '0;
      p_ii_o  <= '0;
      p_ri_o  <= '0;
      p_ir_o  <= '0;
      shift_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        p_rr_o  <= a_re_i * b_re_i;
        p_ii_o  <= a_im_i * b_im_i;
        p_ri_o  <= a_re_i * b_im_i;
        p_ir_o  <= a_im_i * b_re_i;
        shift_o <= shift_i;
      end
    end
  end
endmodule

// File: rtl/cmul_sum_round.sv
module cmul_sum_round #(
  parameter int unsigned DW  = 16,
  parameter int unsigned SHW = 5,
  localparam int unsigned PW = 2 * DW,
  localparam int unsigned SW = PW + 1,
  localparam int unsigned RW = SW + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic signed [PW-1:0]  p_rr_i,
  input  logic signed [PW-1:0]  p_ii_i,
  input  logic signed [PW-1:0]  p_ri_i,
  input  logic signed [PW-1:0]  p_ir_i,
  input  logic [SHW-1:0]        shift_i,
  output logic                  vld_o,
  output logic signed [RW-1:0]  re_o,
  output logic signed [RW-1:0]  im_o,
  output logic [SHW-1:0]        shift_o
);
  logic signed [SW-1:0] re_sum, im_sum;
  logic [RW-1:0]        rnd;

  always_comb begin
    re_sum = SW'(p_rr_i) - SW'(p_ii_i);
    im_sum = SW'(p_ri_i) + SW'(p_ir_i);
    // half-step rounding; shift 0 means exact, no term
    rnd = '0;
    if (shift_i != '0) rnd = RW'(1) << (shift_i - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      re_o    <= '0;
      im_o    <= '0;
      shift_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        re_o    <= RW'(re_sum) + $signed(rnd);
        im_o    <= RW'(im_sum) + $signed(rnd);
        shift_o <= shift_i;
      end
    end
  end
endmodule

// File: rtl/cmul_shift_sat.sv
module cmul_shift_sat #(
  parameter int unsigned RW  = 34,
  parameter int unsigned OW  = 16,
  parameter int unsigned SHW = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic signed [RW-1:0]  val_i,
  input  logic [SHW-1:0]        shift_i,
  output logic signed [OW-1:0]  res_o
);
  logic signed [RW-1:0] shifted;
  logic [RW-OW:0]       top_bits;
  logic signed [OW-1:0] clamped;

  always_comb begin
    shifted  = val_i >>> shift_i;
    top_bits = shifted[RW-1:OW-1];
    // in range only when all bits above the output sign agree
    if ((&top_bits) || !(|top_bits)) clamped = shifted[OW-1:0];
    else if (shifted[RW-1])            clamped = {1'b1, {(OW-1){1'b0}}};
    else                               clamped = {1'b0, {(OW-1){1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (vld_i) res_o <= clamped;
  end
endmodule

// File: rtl/cplx_rnd_mul.sv
module cplx_rnd_mul #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned SHIFT_W = 5,
  localparam int unsigned PW = 2 * DATA_W,
  localparam int unsigned RW = PW + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_vld_i,
  output logic                     in_rdy_o,
  input  logic signed [DATA_W-1:0] a_re_i,
  input  logic signed [DATA_W-1:0] a_im_i,
  input  logic signed [DATA_W-1:0] b_re_i,
  input  logic signed [DATA_W-1:0] b_im_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  output logic                     out_vld_o,
  output logic signed [OUT_W-1:0]  out_re_o,
  output logic signed [OUT_W-1:0]  out_im_o
);
  import cmul_pkg::*;

  logic                 accept;
  logic                 s1_vld, s2_vld;
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic [SHIFT_W-1:0]   s1_shift, s2_shift;
  logic signed [RW-1:0] s2_val [2];
  logic signed [OUT_W-1:0] s3_res [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_rdy_o <= 1'b0;
    else         in_rdy_o <= 1'b1;
  end

  assign accept = in_vld_i & in_rdy_o;

  cmul_prod_stage #(.DW(DATA_W), .SHW(SHIFT_W)) u_prod (
    .clk_i, .rst_ni,
    .vld_i   (accept),
    .a_re_i, .a_im_i, .b_re_i, .b_im_i,
    .shift_i,
    .vld_o   (s1_vld),
    .p_rr_o  (p_rr),
    .p_ii_o  (p_ii),
    .p_ri_o  (p_ri),
    .p_ir_o  (p_ir),
    .shift_o (s1_shift)
  );

  cmul_sum_round #(.DW(DATA_W), .SHW(SHIFT_W)) u_sum (
    .clk_i, .rst_ni,
    .vld_i   (s1_vld),
    .p_rr_i  (p_rr),
    .p_ii_i  (p_ii),
    .p_ri_i  (p_ri),
    .p_ir_i  (p_ir),
    .shift_i (s1_shift),
    .vld_o   (s2_vld),
    .re_o    (s2_val[LANE_RE]),
    .im_o    (s2_val[LANE_IM]),
    .shift_o (s2_shift)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    cmul_shift_sat #(.RW(RW), .OW(OUT_W), .SHW(SHIFT_W)) u_sat (
      .clk_i, .rst_ni,
      .vld_i   (s2_vld),
      .val_i   (s2_val[g]),
      .shift_i (s2_shift),
      .res_o   (s3_res[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_vld_o <= 1'b0;
    else         out_vld_o <= s2_vld;
  end

  assign out_re_o = s3_res[LANE_RE];
  assign out_im_o = s3_res[LANE_IM];
endmodule

// File: rtl/cplx_rnd_mul_chk.sv
module cplx_rnd_mul_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned OW = 16,
  parameter int unsigned SHW = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_vld_i,
  input logic                 in_rdy_o,
  input logic signed [DW-1:0] a_re_i,
  input logic signed [DW-1:0] a_im_i,
  input logic signed [DW-1:0] b_re_i,
  input logic signed [DW-1:0] b_im_i,
  input logic [SHW-1:0]       shift_i,
  input logic                 out_vld_o,
  input logic signed [OW-1:0] out_re_o,
  input logic signed [OW-1:0] out_im_o
);
  logic acc;
  assign acc = in_vld_i & in_rdy_o;

  // R7 R8: valid follows acceptance by exactly three edges
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o == $past(acc, 3));

  // R10: once ready, stays ready
  a_r10_ready_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rdy_o |=> in_rdy_o);

  // R1 R2: zero sample gives zero product on both parts
  a_r1_zero_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc && a_re_i == '0 && a_im_i == '0, 3) |-> (out_re_o == '0 && out_im_o == '0));

  // R2 R3: purely real operands leave the imaginary part at zero after rounding
  a_r2_imag_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc && a_im_i == '0 && b_im_i == '0, 3) |-> out_im_o == '0);

  // R6: max*max at shift 0 clamps to the positive limit
  a_r6_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc && shift_i == '0 && a_im_i == '0 && a_re_i == {1'b0, {(DW-1){1'b1}}}
          && b_re_i == {1'b0, {(DW-1){1'b1}}}, 3)
    |-> out_re_o == {1'b0, {(OW-1){1'b1}}});
endmodule

bind cplx_rnd_mul cplx_rnd_mul_chk #(.DW(DATA_W), .OW(OUT_W), .SHW(SHIFT_W)) u_chk (.*);

// File: tb/cplx_rnd_mul_bench.sv
module cplx_rnd_mul_bench;
  localparam int NEXP = 32768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic in_rdy;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic [4:0] shift = '0;
  logic out_vld;
  logic signed [15:0] out_re, out_im;

  int checks = 0, fails = 0, cyc = 0, sent = 0, rcvd = 0;
  bit done = 1'b0;
  int exp_re [NEXP];
  int exp_im [NEXP];
  int exp_cyc [NEXP];
  string exp_tag [NEXP];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cplx_rnd_mul u_cplx_rnd_mul (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_rdy_o(in_rdy),
    .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im), .shift_i(shift),
    .out_vld_o(out_vld), .out_re_o(out_re), .out_im_o(out_im)
  );

  function automatic int ref_part(longint sum, int sh);
    longint v = sum;
    if (sh > 0) v = v + (64'sd1 <<< (sh - 1));
    v = v >>> sh;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return int'(v);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(int ar, int ai, int br, int bi, int sh, string tag);
    longint re, im;
    @(negedge clk);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    shift = 5'(sh); in_vld = 1'b1;
    re = longint'(ar) * br - longint'(ai) * bi;
    im = longint'(ar) * bi + longint'(ai) * br;
    exp_re[sent] = ref_part(re, sh);
    exp_im[sent] = ref_part(im, sh);
    exp_cyc[sent] = cyc + 3;
    exp_tag[sent] = tag;
    sent++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      a_re = 16'($urandom); b_im = 16'($urandom);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (rcvd >= sent) begin
        check(1'b0, "R8 spurious valid", 1, 0);
      end else begin
        check(out_re == exp_re[rcvd], {exp_tag[rcvd], " R1 real"}, out_re, exp_re[rcvd]);
        check(out_im == exp_im[rcvd], {exp_tag[rcvd], " R2 imag"}, out_im, exp_im[rcvd]);
        check(cyc == exp_cyc[rcvd], "R7 latency", cyc, exp_cyc[rcvd]);
        rcvd++;
      end
    end
  end

  int corner [5] = '{-32768, -1, 0, 1, 32767};

  initial begin
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R8 valid in reset", out_vld, 0);
    check(in_rdy == 1'b0, "R10 ready in reset", in_rdy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_rdy == 1'b1, "R10 ready after reset", in_rdy, 1);
    check(out_vld == 1'b0, "R8 idle after reset", out_vld, 0);

    // corner sweep over every shift: R3 R4 R5 R6
    for (int s = 0; s < 32; s++)
      for (int i0 = 0; i0 < 5; i0++)
        for (int i1 = 0; i1 < 5; i1++)
          for (int i2 = 0; i2 < 5; i2++)
            for (int i3 = 0; i3 < 5; i3++)
              send(corner[i0], corner[i1], corner[i2], corner[i3], s,
                   (s == 0) ? "R4 R6 sweep" : "R3 R5 R6 sweep");
    idle(5);

    // half-step rounding of negative and positive values at shift 1: R3 R5
    send(-3, 0, 1, 0, 1, "R3 R5 neg half");   // (-3+1)>>>1 = -1
    send(3, 0, 1, 0, 1, "R3 R5 pos half");    // (3+1)>>>1 = 2
    send(-1, 0, 1, 0, 4, "R3 R5 tiny neg");   // (-1+8)>>>4 = 0
    send(16384, 0, 16384, 0, 14, "R3 typical shift");
    idle(4);

    // random operands, per-beat shift, gaps: R1 R2 R9
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      send(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           (k % 2 == 0) ? 14 : int'($urandom_range(0, 31)), "R1 R2 R9 random");
    end
    idle(1);

    // no accepted beats must give no output: R8
    idle(10);
    check(rcvd == sent, "R7 R8 output count", rcvd, sent);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", rcvd, sent);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule